// File: doc/BRIEF.md
# Lockable Watchdog Timer

This block is a watchdog timer with a small memory-mapped register set. It holds a down-counter as wide as the data bus. The counter restarts from a programmable reload value, and it decrements once per clock while the watchdog is switched on. Software must service the timer before the count runs out. When the enabled count steps from 1 to 0, the block raises a one-cycle reset request. The count then reloads on its own and keeps running.

Writes to the reload, control and status registers are blocked by a key-protected guard register. Only one 32-bit key value opens it. The guard and service registers always accept writes, so a locked watchdog can still be serviced. Each accepted write leaves a write-busy window open for a fixed number of cycles. This window shows in the status register. A second accepted write that lands inside the window sets a sticky error flag.

The bus is plain. It has no stall and no back-pressure: a strobe is taken in the cycle it is high. Read data is registered and appears one cycle after the read strobe. The reset-request pin is a plain level output with no handshake.

Top module: `wdog_lockable`

## Requirements
- R1: After reset the reload and count registers both read 0xFFFFFFFF, the control register reads 0, the status register reads 0, the guard register reads 1 (locked) and `rst_req_o` is low.
- R2: Registers sit at byte offsets 0x00 (reload), 0x04 (count, read-only), 0x08 (control), 0x0C (service), 0x10 (guard) and 0x14 (status) from the base address. A read returns its data on `bus_rdata` after the next rising edge. A read of an unmapped or misaligned address returns 0. Writes to unmapped addresses, and to the count register, change nothing.
- R3: An accepted write to the reload register stores the value and loads the counter with it in the same edge. A written value of 0 is stored as 1.
- R4: The count register returns the live count. It drops by one each cycle while enabled and holds its value while disabled.
- R5: Control bit 0 switches the watchdog on (1) or off (0), and it reads back in bit 0.
- R6: A write of any data to the service register reloads the counter from the reload register, even when the block is locked. A reload-register write takes priority over a service write, and a service write takes priority over counting.
- R7: Writing 0x1ACCE551 to the guard register unlocks the block, and writing any other value locks it. A read of the guard register returns the lock state in bit 0, with all other bits 0.
- R8: While the block is locked, writes to the reload, control and status registers are ignored and raise no busy flag.
- R9: After an accepted write, the status bits stay set for 2 cycles: bit 0 for a write to any register, bit 1 for a reload write and bit 2 for a control write. A read issued in the two cycles after the write edge sees them; the third read sees them clear.
- R10: Status bit 3 becomes 1 when an accepted write arrives while bit 0 is still set. It stays at 1 until an accepted status write with data bit 3 high clears it. When a setting write and a clearing write happen in the same edge, setting wins.
- R11: When enabled, the count steps from 1 to 0 and `rst_req_o` is high for exactly that one cycle. The count reads 0 for one cycle and then reloads. With reload value L, the first pulse comes L edges after the enabling write, and the pulses repeat every L+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, taken in the cycle it is high |
| bus_rd | input | 1 | Read strobe, taken in the cycle it is high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid after the edge that took the read |
| rst_req_o | output | 1 | One-cycle reset request on expiry |

## Verification
Each check samples one clock after the edge that should produce its result. Register writes take effect in their own edge. A read reports the state from just before its capture edge. The busy flags hold for exactly two edges after a write. The reset request goes high in the edge that moves the count from 1 to 0.

The bench numbers every edge. It records the edge index of each write and each read, and it derives the expected value from those indices. The expected count at a read is the reload value minus the enabled edges that lie strictly before the capture edge. A monitor logs the edge index of every reset pulse, and these are compared with the enabling edge plus L and plus 2L+1.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;

  localparam int NUM_REGS = 6;
  localparam int SEL_W    = 3;

  typedef enum logic [SEL_W-1:0] {
    RSEL_RELOAD  = 3'd0,
    RSEL_COUNT   = 3'd1,
    RSEL_CTRL    = 3'd2,
    RSEL_SERVICE = 3'd3,
    RSEL_GUARD   = 3'd4,
    RSEL_STATE   = 3'd5
  } reg_sel_e;

  // status word bit positions
  localparam int ST_BUSY_ANY    = 0;
  localparam int ST_BUSY_RELOAD = 1;
  localparam int ST_BUSY_CTRL   = 2;
  localparam int ST_ERR         = 3;
  localparam int ST_W           = 4;

  localparam logic [31:0] UNLOCK_KEY = 32'h1ACC_E551;

endpackage

// File: rtl/wdog_addr_decode.sv
`timescale 1ns/1ps
module wdog_addr_decode
  import wdog_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter logic [31:0] BASE_ADDR = 32'h0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output reg_sel_e          sel
);

  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(NUM_REGS * 4);

  logic [ADDR_W-1:0] offset;

  assign offset = addr - ADDR_W'(BASE_ADDR);
  assign hit    = (offset < SPAN) && (offset[1:0] == 2'b00);
  assign sel    = reg_sel_e'(offset[SEL_W+1:2]);

endmodule

// File: rtl/wdog_access_guard.sv
`timescale 1ns/1ps
module wdog_access_guard
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              guard_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              locked
);

  localparam logic [DATA_W-1:0] KEY = DATA_W'(UNLOCK_KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        locked <= 1'b1;
    else if (guard_wr) locked <= (wdata != KEY);
  end

  // R7
  key_unlocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (guard_wr && wdata == KEY) |=> !locked);

  // R7
  wrong_value_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (guard_wr && wdata != KEY) |=> locked);

endmodule

// File: rtl/wdog_write_tracker.sv
`timescale 1ns/1ps
module wdog_write_tracker #(
  parameter int BUSY_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_any,
  input  logic wr_reload,
  input  logic wr_ctrl,
  input  logic clr_err,
  output logic busy_any,
  output logic busy_reload,
  output logic busy_ctrl,
  output logic err
);

  localparam int CW = $clog2(BUSY_CYCLES + 1);

  logic [CW-1:0] win_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q       <= '0;
      busy_reload <= 1'b0;
      busy_ctrl   <= 1'b0;
    end else if (wr_any) begin
      win_q       <= CW'(BUSY_CYCLES);
      busy_reload <= busy_reload | wr_reload;
      busy_ctrl   <= busy_ctrl | wr_ctrl;
    end else if (win_q != '0) begin
      win_q <= win_q - 1'b1;
      if (win_q == CW'(1)) begin
        busy_reload <= 1'b0;
        busy_ctrl   <= 1'b0;
      end
    end
  end

  assign busy_any = (win_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   err <= 1'b0;
    else if (wr_any && busy_any)  err <= 1'b1;
    else if (clr_err)             err <= 1'b0;
  end

  // R9
  write_opens_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_any |=> busy_any);

  // R9
  reg_flags_inside_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_reload || busy_ctrl) |-> busy_any);

  // R10
  overlap_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && busy_any) |=> err);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !clr_err) |=> err);

endmodule

// File: rtl/wdog_down_counter.sv
`timescale 1ns/1ps
module wdog_down_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_wr,
  input  logic [DATA_W-1:0] load_data,
  input  logic              kick,
  input  logic              en,
  output logic [DATA_W-1:0] reload,
  output logic [DATA_W-1:0] count,
  output logic              expire
);

  logic [DATA_W-1:0] ld_val;

  assign ld_val = (load_data == '0) ? DATA_W'(1) : load_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload <= '1;
      count  <= '1;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (load_wr) begin
        reload <= ld_val;
        count  <= ld_val;
      end else if (kick) begin
        count <= reload;
      end else if (count == '0) begin
        count <= reload;
      end else if (en) begin
        count <= count - 1'b1;
        if (count == DATA_W'(1)) expire <= 1'b1;
      end
    end
  end

  // R4
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load_wr && !kick && count != '0) |=> $stable(count));

  // R11
  expire_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire);

  // R11
  expire_then_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !load_wr && !kick) |=> (count == $past(reload)));

  // R11
  expire_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> (count == '0));

endmodule

// File: rtl/wdog_lockable.sv
`timescale 1ns/1ps
module wdog_lockable
  import wdog_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          DATA_W      = 32,
  parameter logic [31:0] BASE_ADDR   = 32'h0,
  parameter int          BUSY_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req_o
);

  logic              hit;
  reg_sel_e          sel;
  logic              locked;
  logic              en_q;
  logic              busy_any, busy_reload, busy_ctrl, err;
  logic [DATA_W-1:0] reload, count;
  logic              wr_hit, open_wr;
  logic              wr_reload, wr_ctrl, wr_state, wr_service, wr_guard, wr_any;
  logic              clr_err;
  logic [DATA_W-1:0] rd_mux;
  logic [ST_W-1:0]   state_bits;

  wdog_addr_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) dec_i (
    .addr (bus_addr),
    .hit  (hit),
    .sel  (sel)
  );

  assign wr_hit     = bus_wr & hit;
  assign open_wr    = wr_hit & ~locked;
  assign wr_reload  = open_wr & (sel == RSEL_RELOAD);
  assign wr_ctrl    = open_wr & (sel == RSEL_CTRL);
  assign wr_state   = open_wr & (sel == RSEL_STATE);
  assign wr_service = wr_hit  & (sel == RSEL_SERVICE);
  assign wr_guard   = wr_hit  & (sel == RSEL_GUARD);
  assign wr_any     = wr_reload | wr_ctrl | wr_state | wr_service | wr_guard;
  assign clr_err    = wr_state & bus_wdata[ST_ERR];

  wdog_access_guard #(.DATA_W(DATA_W)) guard_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .guard_wr (wr_guard),
    .wdata    (bus_wdata),
    .locked   (locked)
  );

  wdog_write_tracker #(.BUSY_CYCLES(BUSY_CYCLES)) track_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_any      (wr_any),
    .wr_reload   (wr_reload),
    .wr_ctrl     (wr_ctrl),
    .clr_err     (clr_err),
    .busy_any    (busy_any),
    .busy_reload (busy_reload),
    .busy_ctrl   (busy_ctrl),
    .err         (err)
  );

  wdog_down_counter #(.DATA_W(DATA_W)) cnt_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_wr   (wr_reload),
    .load_data (bus_wdata),
    .kick      (wr_service),
    .en        (en_q),
    .reload    (reload),
    .count     (count),
    .expire    (rst_req_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= 1'b0;
    else if (wr_ctrl) en_q <= bus_wdata[0];
  end

  always_comb begin
    state_bits                 = '0;
    state_bits[ST_BUSY_ANY]    = busy_any;
    state_bits[ST_BUSY_RELOAD] = busy_reload;
    state_bits[ST_BUSY_CTRL]   = busy_ctrl;
    state_bits[ST_ERR]         = err;
  end

  always_comb begin
    rd_mux = '0;
    if (hit) begin
      case (sel)
        RSEL_RELOAD: rd_mux = reload;
        RSEL_COUNT:  rd_mux = count;
        RSEL_CTRL:   rd_mux = DATA_W'(en_q);
        RSEL_GUARD:  rd_mux = DATA_W'(locked);
        RSEL_STATE:  rd_mux = DATA_W'(state_bits);
        default:     rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // R8
  locked_ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && wr_hit && sel == RSEL_CTRL) |=> $stable(en_q));

  // R8
  locked_reload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && wr_hit && sel == RSEL_RELOAD) |=> $stable(reload));

  // R2
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !hit) |=> (bus_rdata == '0));

endmodule

// File: tb/wdog_lockable_tb_top.sv
`timescale 1ns/1ps
module wdog_lockable_tb_top;

  localparam logic [31:0] A_RELOAD  = 32'h00;
  localparam logic [31:0] A_COUNT   = 32'h04;
  localparam logic [31:0] A_CTRL    = 32'h08;
  localparam logic [31:0] A_SERVICE = 32'h0C;
  localparam logic [31:0] A_GUARD   = 32'h10;
  localparam logic [31:0] A_STATE   = 32'h14;
  localparam logic [31:0] KEY       = 32'h1ACC_E551;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] addr, wdata;
  logic        wr, rd;
  logic [31:0] rdata;
  logic        rst_req;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;
  int last_wr = 0;
  int last_rd = 0;
  int npulse  = 0;
  int pulse_cyc [64];

  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && rst_req && npulse < 64) begin
      pulse_cyc[npulse] = cyc;
      npulse = npulse + 1;
    end
  end

  wdog_lockable dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (addr),
    .bus_wr    (wr),
    .bus_rd    (rd),
    .bus_wdata (wdata),
    .bus_rdata (rdata),
    .rst_req_o (rst_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_pulse(input logic [31:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0;
    last_wr = cyc;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [31:0] a, input logic [31:0] d);
    wr_pulse(a, d);
    idle(2);
  endtask

  task automatic rd_reg(input logic [31:0] a, output logic [31:0] v);
    addr = a; rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rd = 1'b0;
    last_rd = cyc;
    v = rdata;
  endtask

  initial begin
    #1_000_000;
    n_err++; n_chk++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int ew, ed, k, snap, hold;
    rst_n = 1'b0; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 rst_req", {31'b0, rst_req}, 32'h0);
    rd_reg(A_RELOAD, v);  chk("R1 reload", v, 32'hFFFF_FFFF);
    rd_reg(A_COUNT, v);   chk("R1 count", v, 32'hFFFF_FFFF);
    rd_reg(A_CTRL, v);    chk("R1 ctrl", v, 32'h0);
    rd_reg(A_GUARD, v);   chk("R1 guard", v, 32'h1);
    rd_reg(A_STATE, v);   chk("R1 status", v, 32'h0);

    // R8 locked writes ignored and raise no busy flag
    wr_pulse(A_RELOAD, 32'h5);
    rd_reg(A_STATE, v);   chk("R8 no busy when locked", v, 32'h0);
    idle(2);
    rd_reg(A_RELOAD, v);  chk("R8 reload kept", v, 32'hFFFF_FFFF);
    wr_reg(A_CTRL, 32'h1);
    rd_reg(A_CTRL, v);    chk("R8 ctrl kept", v, 32'h0);

    // R7 key sweep: every single-bit corruption of the key locks
    for (int i = 0; i < 32; i++) begin
      wr_reg(A_GUARD, KEY ^ (32'h1 << i));
      rd_reg(A_GUARD, v); chk("R7 bad key locks", v, 32'h1);
      wr_reg(A_GUARD, KEY);
      rd_reg(A_GUARD, v); chk("R7 key unlocks", v, 32'h0);
    end

    // R3 reload write and zero clamp
    wr_reg(A_RELOAD, 32'h0000_1234);
    rd_reg(A_RELOAD, v);  chk("R3 reload stored", v, 32'h1234);
    rd_reg(A_COUNT, v);   chk("R3 count loaded", v, 32'h1234);
    wr_reg(A_RELOAD, 32'h0);
    rd_reg(A_RELOAD, v);  chk("R3 zero stored as one", v, 32'h1);
    rd_reg(A_COUNT, v);   chk("R3 count one", v, 32'h1);

    // R2 unmapped / read-only accesses
    wr_reg(32'h18, 32'h77);
    rd_reg(32'h18, v);    chk("R2 unmapped read", v, 32'h0);
    rd_reg(32'h06, v);    chk("R2 misaligned read", v, 32'h0);
    wr_reg(A_COUNT, 32'h55);
    rd_reg(A_COUNT, v);   chk("R2 count write ignored", v, 32'h1);
    rd_reg(A_RELOAD, v);  chk("R2 reload untouched", v, 32'h1);
    rd_reg(A_SERVICE, v); chk("R2 service reads zero", v, 32'h0);

    // R9 busy window for each kind of write
    wr_pulse(A_RELOAD, 32'h9);
    for (int j = 0; j < 3; j++) begin
      rd_reg(A_STATE, v); chk("R9 reload busy", v, (j < 2) ? 32'h3 : 32'h0);
    end
    wr_pulse(A_CTRL, 32'h0);
    for (int j = 0; j < 3; j++) begin
      rd_reg(A_STATE, v); chk("R9 ctrl busy", v, (j < 2) ? 32'h5 : 32'h0);
    end
    wr_pulse(A_GUARD, KEY);
    for (int j = 0; j < 3; j++) begin
      rd_reg(A_STATE, v); chk("R9 any busy", v, (j < 2) ? 32'h1 : 32'h0);
    end

    // R10 overlap sweep over write spacing
    for (int gap = 0; gap < 4; gap++) begin
      wr_pulse(A_RELOAD, 32'd40);
      idle(gap);
      wr_pulse(A_CTRL, 32'h0);
      idle(2);
      rd_reg(A_STATE, v); chk("R10 overlap flag", v, (gap < 2) ? 32'h8 : 32'h0);
      wr_reg(A_STATE, 32'h8);
      rd_reg(A_STATE, v); chk("R10 clear", v, 32'h0);
    end
    wr_pulse(A_CTRL, 32'h0);
    wr_pulse(A_CTRL, 32'h0);
    idle(2);
    wr_reg(A_STATE, 32'h0);
    rd_reg(A_STATE, v);   chk("R10 sticky without bit3", v, 32'h8);
    wr_reg(A_GUARD, 32'h0);
    wr_reg(A_STATE, 32'h8);
    rd_reg(A_STATE, v);   chk("R8 locked clear ignored", v, 32'h8);
    wr_reg(A_GUARD, KEY);
    wr_reg(A_STATE, 32'h8);
    rd_reg(A_STATE, v);   chk("R10 clear after unlock", v, 32'h0);
    wr_pulse(A_CTRL, 32'h0);
    wr_pulse(A_STATE, 32'h8);
    idle(2);
    rd_reg(A_STATE, v);   chk("R10 set beats clear", v, 32'h8);
    wr_reg(A_STATE, 32'h8);

    // R4 / R5 live count while enabled, hold while disabled
    wr_reg(A_RELOAD, 32'd100);
    wr_pulse(A_CTRL, 32'h1);
    ew = last_wr;
    for (int j = 0; j < 4; j++) begin
      idle(j);
      rd_reg(A_COUNT, v);
      chk("R4 live count", v, 32'(100 - (last_rd - 1 - ew)));
    end
    rd_reg(A_CTRL, v);    chk("R5 ctrl reads on", v, 32'h1);
    wr_pulse(A_CTRL, 32'h0);
    ed = last_wr;
    hold = 100 - (ed - ew);
    idle(3);
    rd_reg(A_COUNT, v);   chk("R4 hold when off", v, 32'(hold));
    idle(5);
    rd_reg(A_COUNT, v);   chk("R4 still held", v, 32'(hold));
    rd_reg(A_CTRL, v);    chk("R5 ctrl reads off", v, 32'h0);

    // R6 service while locked
    wr_reg(A_GUARD, 32'h0);
    wr_reg(A_SERVICE, 32'hDEAD_BEEF);
    rd_reg(A_COUNT, v);   chk("R6 kick when locked", v, 32'd100);
    wr_reg(A_GUARD, KEY);
    wr_reg(A_CTRL, 32'h1);
    idle(6);
    wr_reg(A_GUARD, 32'h0);
    wr_pulse(A_SERVICE, 32'h0);
    k = last_wr;
    idle(1);
    rd_reg(A_COUNT, v);   chk("R6 kick reloads running count", v, 32'(100 - (last_rd - 1 - k)));
    rd_reg(A_RELOAD, v);  chk("R6 reload untouched", v, 32'd100);
    wr_reg(A_GUARD, KEY);
    wr_reg(A_CTRL, 32'h0);

    // R11 expiry sweep over small reload values
    for (int L = 1; L <= 6; L++) begin
      wr_reg(A_RELOAD, 32'(L));
      snap = npulse;
      wr_pulse(A_CTRL, 32'h1);
      ew = last_wr;
      idle(2 * L + 4);
      chk("R11 pulse count", 32'(npulse - snap >= 2), 32'h1);
      chk("R11 first pulse", 32'(pulse_cyc[snap]), 32'(ew + L));
      chk("R11 second pulse", 32'(pulse_cyc[snap + 1]), 32'(ew + 2 * L + 1));
      wr_reg(A_CTRL, 32'h0);
      idle(2);
    end
    chk("R11 idle after disable", {31'b0, rst_req}, 32'h0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule